// File: doc/BRIEF.md
# Parallel Port Control Word Decoder

This block holds the configuration state of a three-port parallel I/O interface with two 8-bit ports (A and B) and a third port (C) split into an upper and a lower 4-bit half. A host reaches the block through a small asynchronous bus made of chip select, read strobe, write strobe, a 2-bit port address and an 8-bit data byte. Address 00 selects port A, address 01 selects port B, address 10 selects port C, and address 11 is a write-only control address.

Every byte written to the control address is routed by its bit 7 to one of two commands. A mode word loads the direction of every port and the operating mode of ports A and B. A bit command sets or clears one bit of the port C output latch. That latch also serves as the way to arm the strobed-handshake interrupt enables of ports A and B. Writing a mode word always disarms both enables.

The write strobe is synchronized to the system clock. A small state machine with the states IDLE, ARMED and COMMIT turns each bus write into exactly one register update. The transitions are IDLE to ARMED when the synchronized strobe falls, ARMED to COMMIT when it rises, and COMMIT back to IDLE, or straight to ARMED if the strobe is already low again. The update is applied on the clock edge that leaves COMMIT.

Top module: `ppi_ctrl_decoder`

## Requirements
- R1: Configuration state changes only for a write with cs_n low and addr = 11. Writes to addresses 00, 01 and 10, and writes with cs_n high, leave every configuration output unchanged.
- R2: A control byte with bit 7 = 1 is a mode word, which leaves pc_out unchanged. A control byte with bit 7 = 0 is a bit command, which leaves every mode and direction output unchanged.
- R3: The mode word bits map as follows: bit 4 drives a_is_in, bit 3 drives cu_is_in, bit 2 drives b_mode1, bit 1 drives b_is_in and bit 0 drives cl_is_in, where 1 means input. 0x92 gives A and B inputs and all of C outputs. 0x8A gives A output, B input, upper C input and lower C output. Both words leave A and B in mode 0.
- R4: Mode word bits 6:5 select the port A mode on a_mode: 00 gives 2'b00 (basic), 01 gives 2'b01 (strobed) and 1x gives 2'b10 (bidirectional). a_mode never shows 2'b11.
- R5: In a bit command, bits 3:1 are the index of the pc_out bit to change, and bit 0 is the value written to that bit. Bits 6:4 are ignored, and the other seven bits keep their values.
- R6: After reset, a_mode = 00, b_mode1 = 0, all four direction outputs = 1 (input), both interrupt enables = 0 and pc_out = 0x00.
- R7: Writing any mode word clears a_irq_en and b_irq_en.
- R8: When b_mode1 = 1, a bit command on index 2 writes its value bit to b_irq_en. When b_mode1 = 0, such a command leaves b_irq_en unchanged.
- R9: When a_mode = 01 and a_is_in = 1, a bit command on index 4 writes its value bit to a_irq_en. When a_mode = 01 and a_is_in = 0, a bit command on index 6 does the same. In both of these modes a command on the other of the two indices leaves a_irq_en unchanged.
- R10: bus_oe is 1 exactly when cs_n = 0, rd_n = 0 and wr_n = 1. During such a read, dout is 0x00 at address 11, and port_rd_sel is one-hot with bit n set for address n (n = 0, 1, 2) and all zero for address 11. A read does not change any configuration output.
- R11: One bus write produces exactly one update, however long the strobe stays low. The update becomes visible on the fourth rising clock edge after wr_n rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| addr | input | 2 | Port address (00 A, 01 B, 10 C, 11 control) |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data for the control address |
| bus_oe | output | 1 | Drive enable for the external data-bus buffer |
| port_rd_sel | output | 3 | One-hot read select for ports A, B, C |
| a_mode | output | 2 | Port A mode: 00 basic, 01 strobed, 10 bidirectional |
| a_is_in | output | 1 | Port A direction, 1 = input |
| b_mode1 | output | 1 | Port B strobed mode |
| b_is_in | output | 1 | Port B direction, 1 = input |
| cu_is_in | output | 1 | Port C upper half direction, 1 = input |
| cl_is_in | output | 1 | Port C lower half direction, 1 = input |
| a_irq_en | output | 1 | Port A handshake interrupt enable |
| b_irq_en | output | 1 | Port B handshake interrupt enable |
| pc_out | output | 8 | Port C output latch |

## Verification
On every cycle the assertions check the following: a committed command lasts only one cycle, a mode word leaves both enables cleared and the port C latch untouched, and a bit command leaves the mode fields untouched. They also check that an armed enable always matches the strobed mode of its port, that a_mode never takes its unused code, and that the bus enable and read data follow chip select and the read strobe. The remaining behaviour can only be shown by the bench scenarios. That covers the exact field positions of both command formats (0x92, 0x8A and the 1x mode code), the index-selected enable writes in each port A direction, rejection of writes to the data addresses or with chip select high, and the four-edge latency after the strobe rises.

// File: rtl/ppi_ctrl_pkg.sv
package ppi_ctrl_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int PC_W      = 8;
    localparam int PC_IDX_W  = $clog2(PC_W);

    // control byte fields
    localparam int CMD_KIND_BIT = 7;     // 1: mode word, 0: bit command
    localparam int MW_CL_IN     = 0;
    localparam int MW_B_IN      = 1;
    localparam int MW_B_MODE    = 2;
    localparam int MW_CU_IN     = 3;
    localparam int MW_A_IN      = 4;
    localparam int MW_A_MODE_LO = 5;
    localparam int MW_A_MODE_HI = 6;
    localparam int BC_VAL_BIT   = 0;
    localparam int BC_IDX_LO    = 1;

    // port C indices that double as handshake interrupt enables
    localparam int EN_B_IDX     = 2;
    localparam int EN_A_IN_IDX  = 4;
    localparam int EN_A_OUT_IDX = 6;

    typedef enum logic [1:0] {
        AMODE_BASIC   = 2'b00,
        AMODE_STROBED = 2'b01,
        AMODE_BIDIR   = 2'b10
    } a_mode_e;

    typedef struct packed {
        a_mode_e a_mode;
        logic    a_in;
        logic    b_mode1;
        logic    b_in;
        logic    cu_in;
        logic    cl_in;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{
        a_mode:  AMODE_BASIC,
        a_in:    1'b1,
        b_mode1: 1'b0,
        b_in:    1'b1,
        cu_in:   1'b1,
        cl_in:   1'b1
    };

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_COMMIT = 2'b10
    } wr_state_e;

endpackage

// File: rtl/ppi_strobe_sync.sv
module ppi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES:0] chain;

    assign chain[0] = async_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s+1] <= 1'b1;
            else     chain[s+1] <= chain[s];
        end
    end

    assign sync_out = chain[STAGES];

endmodule

// File: rtl/ppi_cmd_fsm.sv
module ppi_cmd_fsm
    import ppi_ctrl_pkg::*;
#(
    parameter int                DW       = DATA_W,
    parameter int                AW       = ADDR_W,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 2'b11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sync_n,
    input  logic          cs_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          cmd_vld,
    output logic [DW-1:0] cmd_byte
);
    wr_state_e     state, state_nxt;
    logic          cap_hit;
    logic [DW-1:0] cap_byte;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (!wr_sync_n) state_nxt = ST_ARMED;
            ST_ARMED:  if (wr_sync_n)  state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = wr_sync_n ? ST_IDLE : ST_ARMED;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // bus capture while the synchronized strobe is low
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cap_hit  <= 1'b0;
            cap_byte <= '0;
        end else if (!wr_sync_n) begin
            cap_hit  <= !cs_n && (addr == CTL_ADDR);
            cap_byte <= din;
        end
    end

    // outputs
    always_comb begin
        cmd_vld  = 1'b0;
        cmd_byte = cap_byte;
        unique case (state)
            ST_COMMIT: cmd_vld = cap_hit;
            default:   cmd_vld = 1'b0;
        endcase
    end

endmodule

// File: rtl/ppi_cfg_regs.sv
module ppi_cfg_regs
    import ppi_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_vld,
    input  logic [DW-1:0] cmd_byte,
    output port_cfg_t     cfg,
    output logic          en_a,
    output logic          en_b,
    output logic [PW-1:0] pc_q
);
    localparam int IW = $clog2(PW);

    logic          is_mode;
    logic          is_bit;
    logic [IW-1:0] bit_idx;
    logic          bit_val;
    port_cfg_t     cfg_new;
    logic          hit_en_a;
    logic          hit_en_b;

    always_comb begin
        is_mode = cmd_vld &&  cmd_byte[CMD_KIND_BIT];
        is_bit  = cmd_vld && !cmd_byte[CMD_KIND_BIT];
        bit_idx = cmd_byte[BC_IDX_LO +: IW];
        bit_val = cmd_byte[BC_VAL_BIT];

        cfg_new.a_mode  = cmd_byte[MW_A_MODE_HI] ? AMODE_BIDIR :
                          (cmd_byte[MW_A_MODE_LO] ? AMODE_STROBED : AMODE_BASIC);
        cfg_new.a_in    = cmd_byte[MW_A_IN];
        cfg_new.b_mode1 = cmd_byte[MW_B_MODE];
        cfg_new.b_in    = cmd_byte[MW_B_IN];
        cfg_new.cu_in   = cmd_byte[MW_CU_IN];
        cfg_new.cl_in   = cmd_byte[MW_CL_IN];

        hit_en_b = is_bit && cfg.b_mode1 && (bit_idx == IW'(EN_B_IDX));
        hit_en_a = is_bit && (cfg.a_mode == AMODE_STROBED) &&
                   (( cfg.a_in && (bit_idx == IW'(EN_A_IN_IDX))) ||
                    (!cfg.a_in && (bit_idx == IW'(EN_A_OUT_IDX))));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)          cfg <= CFG_RESET;
        else if (is_mode) cfg <= cfg_new;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            en_a <= 1'b0;
            en_b <= 1'b0;
        end else if (is_mode) begin
            en_a <= 1'b0;
            en_b <= 1'b0;
        end else begin
            if (hit_en_a) en_a <= bit_val;
            if (hit_en_b) en_b <= bit_val;
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_pc_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst)                                  pc_q[i] <= 1'b0;
            else if (is_bit && (bit_idx == IW'(i)))   pc_q[i] <= bit_val;
        end
    end

endmodule

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
    import ppi_ctrl_pkg::*;
#(
    parameter int                AW        = ADDR_W,
    parameter int                DW        = DATA_W,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 2'b11,
    parameter logic [DATA_W-1:0] CTL_RDVAL = 8'h00
) (
    input  logic                  cs_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [AW-1:0]         addr,
    output logic                  oe,
    output logic [(1<<AW)-2:0]    port_sel,
    output logic [DW-1:0]         rdata
);
    localparam int NPORT = (1 << AW) - 1;

    assign oe = !cs_n && !rd_n && wr_n;

    for (genvar p = 0; p < NPORT; p++) begin : g_sel
        assign port_sel[p] = oe && (addr == AW'(p));
    end

    assign rdata = (oe && (addr == CTL_ADDR)) ? CTL_RDVAL : '0;

endmodule

// File: rtl/ppi_ctrl_decoder.sv
module ppi_ctrl_decoder
    import ppi_ctrl_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTL_RDVAL   = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       bus_oe,
    output logic [2:0] port_rd_sel,
    output logic [1:0] a_mode,
    output logic       a_is_in,
    output logic       b_mode1,
    output logic       b_is_in,
    output logic       cu_is_in,
    output logic       cl_is_in,
    output logic       a_irq_en,
    output logic       b_irq_en,
    output logic [7:0] pc_out
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = '1;

    logic       wr_sync_n;
    logic       cmd_vld;
    logic [7:0] cmd_byte;
    port_cfg_t  cfg;

    ppi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (wr_n),
        .sync_out (wr_sync_n)
    );

    ppi_cmd_fsm #(.DW(DATA_W), .AW(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_sync_n (wr_sync_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .din       (din),
        .cmd_vld   (cmd_vld),
        .cmd_byte  (cmd_byte)
    );

    ppi_cfg_regs #(.DW(DATA_W), .PW(PC_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd_vld  (cmd_vld),
        .cmd_byte (cmd_byte),
        .cfg      (cfg),
        .en_a     (a_irq_en),
        .en_b     (b_irq_en),
        .pc_q     (pc_out)
    );

    ppi_bus_decode #(.AW(ADDR_W), .DW(DATA_W), .CTL_ADDR(CTL_ADDR),
                     .CTL_RDVAL(CTL_RDVAL)) u_bus (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .oe       (bus_oe),
        .port_sel (port_rd_sel),
        .rdata    (dout)
    );

    assign a_mode   = cfg.a_mode;
    assign a_is_in  = cfg.a_in;
    assign b_mode1  = cfg.b_mode1;
    assign b_is_in  = cfg.b_in;
    assign cu_is_in = cfg.cu_in;
    assign cl_is_in = cfg.cl_in;

endmodule

// File: rtl/ppi_ctrl_checker.sv
module ppi_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic [1:0] addr,
    input logic [7:0] dout,
    input logic       bus_oe,
    input logic       cmd_vld,
    input logic [7:0] cmd_byte,
    input logic [1:0] a_mode,
    input logic       a_is_in,
    input logic       b_mode1,
    input logic       b_is_in,
    input logic       cu_is_in,
    input logic       cl_is_in,
    input logic       a_irq_en,
    input logic       b_irq_en,
    input logic [7:0] pc_out
);
    logic [6:0] mode_vec;
    assign mode_vec = {a_mode, a_is_in, b_mode1, b_is_in, cu_is_in, cl_is_in};

    AST_ONE_UPDATE_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |=> !cmd_vld); // R11

    AST_MODE_WORD_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_byte[7]) |=> (!a_irq_en && !b_irq_en)); // R7

    AST_MODE_WORD_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_byte[7]) |=> $stable(pc_out)); // R2

    AST_BIT_CMD_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !cmd_byte[7]) |=> $stable(mode_vec)); // R2

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld |=> ($stable(mode_vec) && $stable(pc_out) &&
                      $stable(a_irq_en) && $stable(b_irq_en))); // R1

    AST_AMODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        a_mode != 2'b11); // R4

    AST_EN_B_NEEDS_STROBED: assert property (@(posedge clk) disable iff (rst)
        b_irq_en |-> b_mode1); // R8

    AST_EN_A_NEEDS_STROBED: assert property (@(posedge clk) disable iff (rst)
        a_irq_en |-> (a_mode == 2'b01)); // R9

    AST_BUS_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (!bus_oe && dout == 8'h00)); // R10

    AST_CTL_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && addr == 2'b11) |-> (dout == 8'h00)); // R10

endmodule

bind ppi_ctrl_decoder ppi_ctrl_checker u_checker (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .addr     (addr),
    .dout     (dout),
    .bus_oe   (bus_oe),
    .cmd_vld  (cmd_vld),
    .cmd_byte (cmd_byte),
    .a_mode   (a_mode),
    .a_is_in  (a_is_in),
    .b_mode1  (b_mode1),
    .b_is_in  (b_is_in),
    .cu_is_in (cu_is_in),
    .cl_is_in (cl_is_in),
    .a_irq_en (a_irq_en),
    .b_irq_en (b_irq_en),
    .pc_out   (pc_out)
);

// File: tb/test_ppi_ctrl_decoder.sv
module test_ppi_ctrl_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       bus_oe;
    logic [2:0] port_rd_sel;
    logic [1:0] a_mode;
    logic       a_is_in, b_mode1, b_is_in, cu_is_in, cl_is_in;
    logic       a_irq_en, b_irq_en;
    logic [7:0] pc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ppi_ctrl_decoder i_ppi_ctrl_decoder (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .bus_oe(bus_oe),
        .port_rd_sel(port_rd_sel), .a_mode(a_mode), .a_is_in(a_is_in),
        .b_mode1(b_mode1), .b_is_in(b_is_in), .cu_is_in(cu_is_in),
        .cl_is_in(cl_is_in), .a_irq_en(a_irq_en), .b_irq_en(b_irq_en),
        .pc_out(pc_out)
    );

    // expected-state word: {a_mode[1:0], a_in, b_mode1, b_in, cu_in, cl_in, en_a, en_b, pc[7:0]}
    localparam logic [16:0] RESET_STATE = {2'b00, 7'b1011100, 8'h00};

    // vectors: {control byte, expected state after it}
    localparam int NVEC = 19;
    localparam logic [24:0] VEC [NVEC] = '{
        {8'h92, 2'b00, 7'b1010000, 8'h00},  // R3 example 0x92
        {8'h8A, 2'b00, 7'b0011000, 8'h00},  // R3 example 0x8A
        {8'h0B, 2'b00, 7'b0011000, 8'h20},  // R5 set bit 5
        {8'h71, 2'b00, 7'b0011000, 8'h21},  // R5 bits 6:4 ignored
        {8'h0A, 2'b00, 7'b0011000, 8'h01},  // R5 clear bit 5
        {8'h0F, 2'b00, 7'b0011000, 8'h81},  // R5 set bit 7
        {8'hB4, 2'b01, 7'b1100000, 8'h81},  // R4 A strobed in, B strobed out, R2 pc kept
        {8'h05, 2'b01, 7'b1100001, 8'h85},  // R8 arm B
        {8'h09, 2'b01, 7'b1100011, 8'h95},  // R9 arm A via bit 4 (input)
        {8'h0D, 2'b01, 7'b1100011, 8'hD5},  // R9 bit 6 no effect on A in input
        {8'h08, 2'b01, 7'b1100001, 8'hC5},  // R9 disarm A via bit 4
        {8'hAF, 2'b01, 7'b0111100, 8'hC5},  // R7 mode word clears B enable
        {8'h09, 2'b01, 7'b0111100, 8'hD5},  // R9 bit 4 no effect on A in output
        {8'h0D, 2'b01, 7'b0111110, 8'hD5},  // R9 arm A via bit 6 (output)
        {8'h05, 2'b01, 7'b0111111, 8'hD5},  // R8 arm B
        {8'hC0, 2'b10, 7'b0000000, 8'hD5},  // R4 code 10, R7 clears both
        {8'hE1, 2'b10, 7'b0000100, 8'hD5},  // R4 code 11 gives bidirectional
        {8'h04, 2'b10, 7'b0000100, 8'hD1},  // R8 B in mode 0: enable untouched
        {8'h05, 2'b10, 7'b0000100, 8'hD5}   // R8 B in mode 0: enable untouched
    };

    function automatic logic [16:0] cur_state();
        return {a_mode, a_is_in, b_mode1, b_is_in, cu_is_in, cl_is_in,
                a_irq_en, b_irq_en, pc_out};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [16:0] exp);
        logic [16:0] s;
        s = cur_state();
        check({req, " modes"},   {25'd0, s[16:10]}, {25'd0, exp[16:10]});
        check({req, " enables"}, {30'd0, s[9:8]},   {30'd0, exp[9:8]});
        check({req, " pc_out"},  {24'd0, s[7:0]},   {24'd0, exp[7:0]});
    endtask

    task automatic bus_write(input logic cs_lvl, input logic [1:0] a,
                             input logic [7:0] d, input int low_cycles);
        @(negedge clk);
        cs_n = cs_lvl; addr = a; din = d; wr_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [16:0] held;
        do_reset();
        check_state("R6 reset", RESET_STATE);

        for (int i = 0; i < NVEC; i++) begin
            bus_write(1'b0, 2'b11, VEC[i][24:17], 3);
            check_state($sformatf("R2 R3 R4 R5 R7 R8 R9 vec%0d", i), VEC[i][16:0]);
        end

        // R1: writes elsewhere are not taken
        held = cur_state();
        bus_write(1'b0, 2'b00, 8'h80, 3);
        check_state("R1 addr 00", held);
        bus_write(1'b0, 2'b01, 8'h0E, 3);
        check_state("R1 addr 01", held);
        bus_write(1'b0, 2'b10, 8'hFF, 3);
        check_state("R1 addr 10", held);
        bus_write(1'b1, 2'b11, 8'h80, 3);
        check_state("R1 cs high", held);

        // R10: read decode
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'b11; #1;
        check("R10 oe ctl", {31'd0, bus_oe}, 32'd1);
        check("R10 dout ctl", {24'd0, dout}, 32'h00);
        check("R10 sel ctl", {29'd0, port_rd_sel}, 32'd0);
        repeat (6) @(negedge clk);
        addr = 2'b01; #1;
        check("R10 sel B", {29'd0, port_rd_sel}, 32'b010);
        addr = 2'b00; #1;
        check("R10 sel A", {29'd0, port_rd_sel}, 32'b001);
        addr = 2'b10; #1;
        check("R10 sel C", {29'd0, port_rd_sel}, 32'b100);
        cs_n = 1'b1; #1;
        check("R10 oe cs high", {31'd0, bus_oe}, 32'd0);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check_state("R10 read no change", held);

        // R6 again: reset in mid-run
        do_reset();
        check_state("R6 re-reset", RESET_STATE);

        // R11: long strobe, single update on the fourth edge after release
        @(negedge clk);
        cs_n = 1'b0; addr = 2'b11; din = 8'h92; wr_n = 1'b0;
        repeat (20) @(negedge clk);
        check_state("R11 strobe low", RESET_STATE);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R11 before edge 4", RESET_STATE);
        @(negedge clk);
        check_state("R11 edge 4", VEC[0][16:0]);
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check_state("R11 single update", VEC[0][16:0]);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule